// File: doc/BRIEF.md
# Pass-Through Burst Buffer

This block sits on the bridge side of a host-to-add-on pass-through path. The host side opens an access with one address phase, carrying an address, a direction bit and active-low byte enables. It then sends a stream of 32-bit words on a valid/last handshake. The address is compared against a small set of base/mask regions. A hit latches the address and its attributes and opens an access. Each word is then parked in a two-entry buffer and offered to the add-on.

The add-on sees a register-style local port. An active-low attention line reports that a buffered word is waiting. Beside it are status outputs: a burst flag, the region number, the direction and the byte enables. The add-on reads the oldest word at local offset 0x2C and the latched host address at offset 0x1C. It retires each word by pulling its active-low ready low on a rising edge. The burst flag warns that more words follow. It is withdrawn as soon as the host has delivered its final word, while one or two words may still be buffered.

Top module: `pt_burst_bridge`

## Requirements
- R1: An address phase accepted while idle that matches a region latches the address, direction, byte enables and region number. The lowest-numbered matching region wins. A region matches when (address AND mask) equals (base AND mask). A local read at offset 0x1C returns the latched address.
- R2: An address phase that matches no region, or that arrives while an access is open, opens nothing: the host ready and the attention line stay inactive.
- R3: Attention (active low) is asserted exactly while an access is open and at least one word is buffered. It drops when the host stalls and the buffer runs empty, and it returns with the next word.
- R4: While attention is asserted, the region, direction and byte-enable outputs hold the values latched at the address phase.
- R5: A local read at offset 0x2C, with select and read both low, returns the oldest buffered word, or zero when the buffer is empty. A read at any other offset, or with select or read high, returns zero.
- R6: Ready seen low on a rising edge while attention is asserted retires the oldest word, and the next word becomes visible. Ready seen high holds the presented word. Ready while attention is inactive has no effect.
- R7: The host ready is high only while an access is open, fewer than two words are buffered and the last word has not yet arrived. Words are delivered in arrival order.
- R8: The burst flag (active low) is inactive when an access opens. It goes active once a word without the last marker is accepted. It goes inactive once the word carrying the last marker is accepted.
- R9: When the final word is retired, attention goes inactive, the access closes, and an address phase on the next clock is accepted.
- R10: During and right after reset, attention and the burst flag are inactive and the host ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_addr_vld | input | 1 | Host address phase strobe |
| hst_addr | input | 32 | Host address |
| hst_wr | input | 1 | Host direction bit |
| hst_be_n | input | 4 | Host byte enables, active low |
| hst_dat_vld | input | 1 | Host word valid |
| hst_dat | input | 32 | Host word |
| hst_dat_last | input | 1 | Marks the final word of the access |
| hst_dat_rdy | output | 1 | Buffer can take a host word |
| ao_sel_n | input | 1 | Local register select, active low |
| ao_rd_n | input | 1 | Local read strobe, active low |
| ao_adr | input | 6 | Local byte offset |
| ao_rdy_n | input | 1 | Add-on ready, active low, retires a word |
| ao_dout | output | 32 | Local read data |
| pt_attn_n | output | 1 | Attention, active low |
| pt_burst_n | output | 1 | Burst flag, active low |
| pt_region | output | 2 | Number of the matched region |
| pt_wr | output | 1 | Latched direction |
| pt_be_n | output | 4 | Latched byte enables, active low |

## Verification
The bench builds the block with four regions and a buffer depth of two. Region 3 is given a wide mask that overlaps region 1, so some addresses hit both and the lowest-index rule is exercised. A depth of two makes a full buffer frequent under random ready stalls, which brings host back-pressure and the withdrawal of the burst flag with two words still buffered into reach. Random host stalls also empty the buffer in mid-access, so attention drops and returns.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [0:0] {
    PT_IDLE   = 1'b0,
    PT_ACTIVE = 1'b1
  } pt_state_e;
endpackage

// File: rtl/pt_region_dec.sv
module pt_region_dec #(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter int RW   = 2,
  parameter logic [NREG*AW-1:0] BASE = '0,
  parameter logic [NREG*AW-1:0] MASK = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [RW-1:0] idx_o
);
  logic [NREG-1:0] match;

  for (genvar r = 0; r < NREG; r++) begin : g_region
    localparam logic [AW-1:0] RB = BASE[r*AW +: AW];
    localparam logic [AW-1:0] RM = MASK[r*AW +: AW];
    assign match[r] = ((addr_i ^ RB) & RM) == '0;
  end

  // lowest index has priority: scan downward so it is written last
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (match[r]) idx_o = RW'(r);
    end
  end
endmodule

// File: rtl/pt_dbuf.sv
module pt_dbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_i) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_i)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // data storage: enable only, no reset
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= din_i;
  end

  assign head_o = mem_q[rptr_q];
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RW  = 2,
  parameter int BEW = 4,
  parameter int CW  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           addr_vld_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  input  logic [BEW-1:0] be_n_i,
  input  logic           hit_i,
  input  logic [RW-1:0]  idx_i,
  input  logic           dat_vld_i,
  input  logic           dat_last_i,
  input  logic           rdy_n_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic           full_i,
  output logic           active_o,
  output logic           dat_rdy_o,
  output logic           push_o,
  output logic           pop_o,
  output logic           attn_n_o,
  output logic           burst_n_o,
  output logic [AW-1:0]  addr_o,
  output logic [RW-1:0]  region_o,
  output logic           wr_o,
  output logic [BEW-1:0] be_n_o
);
  pt_state_e      st_q, st_d;
  logic           last_q, last_d;
  logic           burst_q, burst_d;
  logic [AW-1:0]  addr_q;
  logic [RW-1:0]  region_q;
  logic           wr_q;
  logic [BEW-1:0] be_n_q;

  logic          active, has_data, dat_rdy, push, pop, start, done;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    active   = (st_q == PT_ACTIVE);
    has_data = (cnt_i != '0);
    dat_rdy  = active && !full_i && !last_q;
    push     = dat_rdy && dat_vld_i;
    pop      = active && has_data && !rdy_n_i;
    cnt_nx   = cnt_i + CW'(push) - CW'(pop);
    start    = !active && addr_vld_i && hit_i;
    done     = active && last_q && (cnt_nx == '0);

    st_d    = st_q;
    last_d  = last_q;
    burst_d = burst_q;
    if (start) begin
      st_d    = PT_ACTIVE;
      last_d  = 1'b0;
      burst_d = 1'b0;
    end else if (done) begin
      st_d    = PT_IDLE;
      last_d  = 1'b0;
      burst_d = 1'b0;
    end else if (push) begin
      last_d  = dat_last_i;
      burst_d = !dat_last_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PT_IDLE;
      last_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      last_q  <= last_d;
      burst_q <= burst_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      region_q <= '0;
      wr_q     <= 1'b0;
      be_n_q   <= '1;
    end else if (start) begin
      addr_q   <= addr_i;
      region_q <= idx_i;
      wr_q     <= wr_i;
      be_n_q   <= be_n_i;
    end
  end

  assign active_o  = active;
  assign dat_rdy_o = dat_rdy;
  assign push_o    = push;
  assign pop_o     = pop;
  assign attn_n_o  = !(active && has_data);
  assign burst_n_o = !burst_q;
  assign addr_o    = addr_q;
  assign region_o  = region_q;
  assign wr_o      = wr_q;
  assign be_n_o    = be_n_q;

  assert_latch_on_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && addr_vld_i && hit_i) |=>
      (active_o && region_o == $past(idx_i) && addr_o == $past(addr_i)));
  assert_miss_stays_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && addr_vld_i && !hit_i) |=> !active_o);
  assert_status_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!attn_n_o && $past(!attn_n_o)) |->
      ($stable(region_o) && $stable(wr_o) && $stable(be_n_o)));
  assert_burst_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> burst_n_o);
  assert_burst_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && dat_last_i) |=> burst_n_o);
  assert_close_after_final_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_q && pop_o && cnt_i == CW'(1)) |=> (attn_n_o && !active_o));
endmodule

// File: rtl/pt_burst_bridge.sv
module pt_burst_bridge #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NREG  = 4,
  parameter int DEPTH = 2,
  parameter int LAW   = 6,
  parameter logic [LAW-1:0] DATA_OFS = 6'h2C,
  parameter logic [LAW-1:0] ADDR_OFS = 6'h1C,
  parameter logic [NREG*AW-1:0] REG_BASE = {32'h2000_0000, 32'h3000_0000,
                                            32'h2000_0000, 32'h1000_0000},
  parameter logic [NREG*AW-1:0] REG_MASK = {32'hF000_0000, 32'hFF00_0000,
                                            32'hFFFF_0000, 32'hFFFF_0000},
  localparam int BEW  = DW / 8,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hst_addr_vld,
  input  logic [AW-1:0]  hst_addr,
  input  logic           hst_wr,
  input  logic [BEW-1:0] hst_be_n,
  input  logic           hst_dat_vld,
  input  logic [DW-1:0]  hst_dat,
  input  logic           hst_dat_last,
  output logic           hst_dat_rdy,
  input  logic           ao_sel_n,
  input  logic           ao_rd_n,
  input  logic [LAW-1:0] ao_adr,
  input  logic           ao_rdy_n,
  output logic [DW-1:0]  ao_dout,
  output logic           pt_attn_n,
  output logic           pt_burst_n,
  output logic [RW-1:0]  pt_region,
  output logic           pt_wr,
  output logic [BEW-1:0] pt_be_n
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          hit;
  logic [RW-1:0] hit_idx;
  logic          active, push, pop, full;
  logic [CW-1:0] cnt;
  logic [DW-1:0] head;
  logic [AW-1:0] addr_lat;

  pt_region_dec #(
    .AW(AW), .NREG(NREG), .RW(RW), .BASE(REG_BASE), .MASK(REG_MASK)
  ) u_dec (
    .addr_i (hst_addr),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  pt_ctrl #(
    .AW(AW), .RW(RW), .BEW(BEW), .CW(CW)
  ) u_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .addr_vld_i (hst_addr_vld),
    .addr_i     (hst_addr),
    .wr_i       (hst_wr),
    .be_n_i     (hst_be_n),
    .hit_i      (hit),
    .idx_i      (hit_idx),
    .dat_vld_i  (hst_dat_vld),
    .dat_last_i (hst_dat_last),
    .rdy_n_i    (ao_rdy_n),
    .cnt_i      (cnt),
    .full_i     (full),
    .active_o   (active),
    .dat_rdy_o  (hst_dat_rdy),
    .push_o     (push),
    .pop_o      (pop),
    .attn_n_o   (pt_attn_n),
    .burst_n_o  (pt_burst_n),
    .addr_o     (addr_lat),
    .region_o   (pt_region),
    .wr_o       (pt_wr),
    .be_n_o     (pt_be_n)
  );

  pt_dbuf #(
    .DW(DW), .DEPTH(DEPTH)
  ) u_buf (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .push_i (push),
    .din_i  (hst_dat),
    .pop_i  (pop),
    .head_o (head),
    .cnt_o  (cnt),
    .full_o (full)
  );

  // local register read port
  logic rd_en;
  always_comb begin
    rd_en   = !ao_sel_n && !ao_rd_n;
    ao_dout = '0;
    if (rd_en && ao_adr == DATA_OFS) begin
      ao_dout = (cnt != '0) ? head : '0;
    end else if (rd_en && ao_adr == ADDR_OFS) begin
      ao_dout = DW'(addr_lat);
    end
  end

  assert_hold_on_wait_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pt_attn_n && ao_rdy_n) |=> (!pt_attn_n && $stable(head)));
  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    full |-> !hst_dat_rdy);
  assert_idle_no_data_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !active |-> (pt_attn_n && !hst_dat_rdy));
endmodule

// File: tb/pt_burst_bridge_tb.sv
module pt_burst_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] TB_BASE = {32'h2000_0000, 32'h3000_0000,
                                      32'h2000_0000, 32'h1000_0000};
  localparam logic [127:0] TB_MASK = {32'hF000_0000, 32'hFF00_0000,
                                      32'hFFFF_0000, 32'hFFFF_0000};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_addr_vld, hst_wr, hst_dat_vld, hst_dat_last;
  logic [31:0] hst_addr, hst_dat;
  logic [3:0]  hst_be_n;
  logic        hst_dat_rdy;
  logic        ao_sel_n, ao_rd_n, ao_rdy_n;
  logic [5:0]  ao_adr;
  logic [31:0] ao_dout;
  logic        pt_attn_n, pt_burst_n, pt_wr;
  logic [1:0]  pt_region;
  logic [3:0]  pt_be_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pt_burst_bridge #(.REG_BASE(TB_BASE), .REG_MASK(TB_MASK)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .hst_addr_vld(hst_addr_vld), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_be_n(hst_be_n), .hst_dat_vld(hst_dat_vld), .hst_dat(hst_dat),
    .hst_dat_last(hst_dat_last), .hst_dat_rdy(hst_dat_rdy),
    .ao_sel_n(ao_sel_n), .ao_rd_n(ao_rd_n), .ao_adr(ao_adr),
    .ao_rdy_n(ao_rdy_n), .ao_dout(ao_dout),
    .pt_attn_n(pt_attn_n), .pt_burst_n(pt_burst_n), .pt_region(pt_region),
    .pt_wr(pt_wr), .pt_be_n(pt_be_n)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string ctx      = "reset";
  bit    finished = 1'b0;

  // reference model state
  bit          m_active = 0, m_last = 0, m_burst = 0;
  logic [31:0] m_addr = '0;
  int          m_region = 0;
  bit          m_wr = 0;
  logic [3:0]  m_be = 4'hF;
  logic [31:0] mq [$];
  logic [31:0] word_ctr = 32'hA000_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  function automatic int exp_region(input logic [31:0] a);
    for (int r = 0; r < 4; r++) begin
      if ((a & TB_MASK[r*32 +: 32]) == (TB_BASE[r*32 +: 32] & TB_MASK[r*32 +: 32]))
        return r;
    end
    return -1;
  endfunction

  function automatic logic [31:0] exp_dout(input bit sel_n, input bit rd_n, input logic [5:0] adr);
    if (sel_n || rd_n) return '0;
    if (adr == 6'h2C) return (mq.size() > 0) ? mq[0] : 32'h0;
    if (adr == 6'h1C) return m_addr;
    return '0;
  endfunction

  // one clock: drive at the falling edge, check, then advance the model at the rising edge
  task automatic step(input bit avld, input logic [31:0] addr, input bit wr, input logic [3:0] be,
                      input bit dvld, input bit last, input bit sel_n, input bit rd_n,
                      input logic [5:0] adr, input bit rdy_n);
    bit exp_rdy, push, pop, was_active;
    int reg_i;
    logic [31:0] dat;
    @(negedge clk);
    dat = word_ctr ^ $urandom;
    hst_addr_vld = avld; hst_addr = addr; hst_wr = wr; hst_be_n = be;
    hst_dat_vld = dvld; hst_dat = dat; hst_dat_last = last;
    ao_sel_n = sel_n; ao_rd_n = rd_n; ao_adr = adr; ao_rdy_n = rdy_n;
    #1;
    exp_rdy = m_active && (mq.size() < 2) && !m_last;
    check("R3", 32'(pt_attn_n), 32'(!(m_active && mq.size() > 0)));
    check("R8", 32'(pt_burst_n), 32'(!m_burst));
    check("R7", 32'(hst_dat_rdy), 32'(exp_rdy));
    check((adr == 6'h1C) ? "R1" : "R5", ao_dout, exp_dout(sel_n, rd_n, adr));
    if (!pt_attn_n) begin
      check("R1", 32'(pt_region), 32'(m_region));
      check("R4", {27'd0, pt_wr, pt_be_n}, {27'd0, m_wr, m_be});
    end
    @(posedge clk);
    push = dvld && exp_rdy;
    pop  = m_active && (mq.size() > 0) && !rdy_n;
    was_active = m_active;
    if (pop) void'(mq.pop_front());
    if (push) begin
      mq.push_back(dat);
      word_ctr = word_ctr + 1;
      if (last) m_last = 1;
      m_burst = !last;
    end
    reg_i = exp_region(addr);
    if (was_active && m_last && mq.size() == 0) begin
      m_active = 0; m_last = 0; m_burst = 0;
    end else if (!was_active && avld && reg_i >= 0) begin
      m_active = 1; m_last = 0; m_burst = 0;
      m_addr = addr; m_region = reg_i; m_wr = wr; m_be = be;
    end
  endtask

  task automatic idle_step(input logic [5:0] adr, input bit rdy_n);
    step(0, 32'h0, 0, 4'hF, 0, 0, 0, 0, adr, rdy_n);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    hst_addr_vld = 0; hst_addr = '0; hst_wr = 0; hst_be_n = 4'hF;
    hst_dat_vld = 0; hst_dat = '0; hst_dat_last = 0;
    ao_sel_n = 1; ao_rd_n = 1; ao_adr = '0; ao_rdy_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", 32'(pt_attn_n), 32'd1);
    check("R10", 32'(pt_burst_n), 32'd1);
    check("R10", 32'(hst_dat_rdy), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    ctx = "R10";
    idle_step(6'h2C, 1);

    // R2: miss, then a hit followed by an address phase while busy
    ctx = "R2";
    step(1, 32'h4000_0000, 1, 4'h0, 0, 0, 0, 0, 6'h1C, 1);
    idle_step(6'h1C, 1);
    idle_step(6'h2C, 0);
    // R1: overlapping regions, lowest index wins
    ctx = "R1";
    step(1, 32'h2000_0010, 1, 4'h3, 0, 0, 0, 0, 6'h1C, 1);
    idle_step(6'h1C, 1);
    ctx = "R2";
    step(1, 32'h1000_0000, 0, 4'h0, 0, 0, 0, 0, 6'h1C, 1);
    // R6 and R7: fill with ready held off, hold, then drain
    ctx = "R6";
    step(0, 0, 0, 4'hF, 1, 0, 0, 0, 6'h2C, 1);
    step(0, 0, 0, 4'hF, 1, 0, 0, 0, 6'h2C, 1);
    step(0, 0, 0, 4'hF, 1, 0, 0, 0, 6'h2C, 1);
    ctx = "R7";
    step(0, 0, 0, 4'hF, 1, 0, 0, 0, 6'h2C, 1);
    ctx = "R6";
    step(0, 0, 0, 4'hF, 0, 0, 0, 0, 6'h2C, 0);
    step(0, 0, 0, 4'hF, 0, 0, 0, 0, 6'h2C, 0);
    // R3: buffer empty while host stalls, then a new word
    ctx = "R3";
    idle_step(6'h2C, 0);
    idle_step(6'h2C, 0);
    step(0, 0, 0, 4'hF, 1, 0, 0, 0, 6'h2C, 1);
    // R8: two words still buffered when the flag is withdrawn
    ctx = "R8";
    step(0, 0, 0, 4'hF, 1, 1, 0, 0, 6'h2C, 1);
    idle_step(6'h2C, 1);
    idle_step(6'h2C, 0);
    // R9: final word retired, next address on the following clock
    ctx = "R9";
    step(1, 32'h30AB_CDEF, 0, 4'h0, 0, 0, 0, 0, 6'h2C, 0);
    step(1, 32'h30AB_CDEF, 0, 4'h1, 0, 0, 0, 0, 6'h1C, 1);
    step(0, 0, 0, 4'hF, 1, 1, 0, 0, 6'h1C, 1);
    idle_step(6'h2C, 0);
    idle_step(6'h2C, 0);
    // R5: other offsets and deselected reads
    ctx = "R5";
    step(0, 0, 0, 4'hF, 0, 0, 1, 0, 6'h2C, 1);
    step(0, 0, 0, 4'hF, 0, 0, 0, 1, 6'h1C, 1);

    // constrained random traffic
    ctx = "random";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      logic [5:0]  adr;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 32'h1000_0040;
        1: a = 32'h2000_1234;
        2: a = 32'h2100_0000;
        3: a = 32'h30AB_CDEF;
        4: a = 32'h4000_0000;
        default: a = 32'h2000_0000;
      endcase
      pick = $urandom_range(0, 3);
      adr = (pick == 0) ? 6'h1C : (pick == 1) ? 6'h10 : 6'h2C;
      step($urandom_range(0, 3) == 0, a, 1'($urandom), 4'($urandom),
           $urandom_range(0, 9) < 6, $urandom_range(0, 4) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, adr,
           1'($urandom));
    end

    finished = 1'b1;
    report();
    $finish;
  end
endmodule